// File: doc/BRIEF.md
# Watchdog Timer with Guarded Shutdown

This block is a watchdog that runs on its own oscillator clock. A write port, synchronous to that clock, updates three fields together: a run bit, an unlock bit and a 3-bit period select. While the run bit is set, a counter advances on every clock. When it reaches the period chosen by the select code, the block raises a reset request for one cycle and starts counting again. Software keeps the system alive by pulsing the kick input before the period runs out.

Starting the watchdog takes a single write. Stopping it is guarded. One write must set the unlock bit and the run bit together. A write that clears the run bit then has to follow within four clock cycles. The unlock bit drops by itself after that window. A safety-level input can hold the watchdog on permanently. A reset-default input picks whether the watchdog comes out of reset running. A parameter divides every period by a power of two, so that short simulations remain practical.

Top module: `wdog_core`

## Requirements
- R1: Reset release is synchronised by two flops. After reset: `wdt_en` equals `en_default`, `chg_en` is 0, `psel` is 0, `wdt_rst_req` is 0 and the count is zero. With `en_default` = 1 and `psel` = 0, the first request appears 2 + 2^(14−DIV_SHIFT) clocks after `rst_n` rises.
- R2: A write with `wr_enable` = 1 sets `wdt_en` at the write edge. The run bit rises only through such a write or through the safety lock.
- R3: A write with `wr_enable` = 1 and `wr_chg_en` = 1 sets `chg_en` and restarts its window. `chg_en` reads 1 for exactly the four clock cycles after that edge and is 0 from then on. A write that carries `wr_chg_en` = 1 without `wr_enable` = 1 does not set it.
- R4: A write with `wr_enable` = 0 clears `wdt_en` only while `chg_en` is 1 and `safety_lvl` is not 2'b10. With the unlocking write at edge T0, clearing writes at edges T1 through T4 take effect.
- R5: A write with `wr_enable` = 0 while `chg_en` is 0 leaves `wdt_en` unchanged. This covers a clear arriving after the window has closed, and a clear whose preceding write did not carry `wr_enable` = 1.
- R6: While `safety_lvl` = 2'b10, `wdt_en` is forced to 1 on the next edge and stays 1 even if the full unlock sequence is followed. The other safety levels do not lock.
- R7: Select code s (0 to 7) gives a period of 2^(14+s−DIV_SHIFT) clocks. 000 means 16K cycles, and each step up doubles the period, to 2048K at 111. `wdt_rst_req` is high for one cycle. The count then restarts, so requests repeat with that period.
- R8: A `kick` pulse restarts the count from zero. No request occurs in the cycle after a kick, and the next request comes one full period after it.
- R9: A write that changes the select code restarts the count. A write that carries the current code does not disturb the count.
- R10: While `wdt_en` is 0, no request is raised and the count is held at zero. Enabling therefore yields a full first period.
- R11: `psel` takes the value of `wr_psel` on every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_default | input | 1 | Value of the run bit after reset |
| safety_lvl | input | 2 | Safety level; 2'b10 locks the watchdog on |
| wr_en | input | 1 | Register write strobe |
| wr_enable | input | 1 | Run bit value written |
| wr_chg_en | input | 1 | Unlock bit value written |
| wr_psel | input | 3 | Period select written |
| kick | input | 1 | Restart the count |
| wdt_en | output | 1 | Current run bit |
| chg_en | output | 1 | Current unlock bit |
| psel | output | 3 | Current period select |
| wdt_rst_req | output | 1 | One-cycle reset request |

## Verification
On every cycle, the checker enforces four rules. No falling edge of the run bit may occur without an open unlock window and an unlocked safety level. The unlock bit may never outlive its four-cycle window. The request must be a single-cycle pulse that only a running watchdog raises. The select readback must follow each write. Only the bench scenarios can show the exact period of each of the eight select codes, the cycle-exact edges of the unlock window, a kick or select change moving the next request, and the first request after a reset that comes up running.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned BASE_LOG2  = 14;  // select 000 => 2^14 cycles
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned NSEL       = 1 << SEL_W;
  localparam int unsigned UNLOCK_WIN = 4;   // cycles the unlock bit stays open
  localparam logic [1:0]  SAFE_LOCK  = 2'b10;

  typedef logic [SEL_W-1:0] psel_t;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      s1_q    <= 1'b1;
      rst_q_n <= s1_q;
    end
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_default,
  input  logic [1:0] safety_lvl,
  input  logic       wr_en,
  input  logic       wr_enable,
  input  logic       wr_chg_en,
  input  psel_t      wr_psel,
  output logic       en_q,
  output logic       chg_q,
  output psel_t      psel_q,
  output logic       sel_restart
);
  localparam int unsigned WIN_W = (UNLOCK_WIN > 1) ? $clog2(UNLOCK_WIN) : 1;

  logic             en_d, chg_d;
  psel_t            psel_d;
  logic [WIN_W-1:0] rem_q, rem_d;
  logic             unlock_wr, locked;

  assign unlock_wr   = wr_en & wr_chg_en & wr_enable;
  assign locked      = (safety_lvl == SAFE_LOCK);
  assign sel_restart = wr_en & (wr_psel != psel_q);

  // run bit
  always_comb begin
    en_d = en_q;
    if (locked)
      en_d = 1'b1;
    else if (wr_en) begin
      if (wr_enable)
        en_d = 1'b1;
      else if (chg_q)
        en_d = 1'b0;
    end
  end

  // unlock bit with self-closing window
  always_comb begin
    chg_d = chg_q;
    rem_d = rem_q;
    if (unlock_wr) begin
      chg_d = 1'b1;
      rem_d = WIN_W'(UNLOCK_WIN - 1);
    end else if (chg_q) begin
      if (rem_q == '0)
        chg_d = 1'b0;
      else
        rem_d = rem_q - WIN_W'(1);
    end
  end

  always_comb begin
    psel_d = psel_q;
    if (wr_en)
      psel_d = wr_psel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= en_default;
      chg_q  <= 1'b0;
      rem_q  <= '0;
      psel_q <= '0;
    end else begin
      en_q  <= en_d;
      chg_q <= chg_d;
      if (unlock_wr | chg_q)
        rem_q <= rem_d;
      if (wr_en)
        psel_q <= psel_d;
    end
  end
endmodule

// File: rtl/wdog_limit.sv
module wdog_limit
  import wdog_pkg::*;
#(
  parameter int unsigned DIV_SHIFT = 0,
  parameter int unsigned CNT_W     = BASE_LOG2 + NSEL - 1 - DIV_SHIFT
) (
  input  psel_t            sel,
  output logic [CNT_W-1:0] term
);
  logic [CNT_W-1:0] term_tab [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_term
    localparam int unsigned SH = BASE_LOG2 + g - DIV_SHIFT;
    assign term_tab[g] = CNT_W'((64'd1 << SH) - 64'd1);
  end

  assign term = term_tab[sel];
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int unsigned CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] term,
  output logic             req_q
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_d, cnt_ce;

  always_comb begin
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (!run || restart)
      cnt_d = '0;
    else if (cnt_q == term) begin
      cnt_d = '0;
      req_d = 1'b1;
    end else
      cnt_d = cnt_q + CNT_W'(1);
  end

  assign cnt_ce = run | (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      if (cnt_ce)
        cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned DIV_SHIFT = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_default,
  input  logic [1:0] safety_lvl,
  input  logic       wr_en,
  input  logic       wr_enable,
  input  logic       wr_chg_en,
  input  logic [2:0] wr_psel,
  input  logic       kick,
  output logic       wdt_en,
  output logic       chg_en,
  output logic [2:0] psel,
  output logic       wdt_rst_req
);
  localparam int unsigned CNT_W = BASE_LOG2 + NSEL - 1 - DIV_SHIFT;

  logic             rst_q_n;
  logic             sel_restart;
  logic [CNT_W-1:0] term;
  psel_t            psel_q;

  wdog_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  wdog_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .en_default  (en_default),
    .safety_lvl  (safety_lvl),
    .wr_en       (wr_en),
    .wr_enable   (wr_enable),
    .wr_chg_en   (wr_chg_en),
    .wr_psel     (wr_psel),
    .en_q        (wdt_en),
    .chg_q       (chg_en),
    .psel_q      (psel_q),
    .sel_restart (sel_restart)
  );

  wdog_limit #(.DIV_SHIFT(DIV_SHIFT), .CNT_W(CNT_W)) u_limit (
    .sel  (psel_q),
    .term (term)
  );

  wdog_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .run     (wdt_en),
    .restart (kick | sel_restart),
    .term    (term),
    .req_q   (wdt_rst_req)
  );

  assign psel = psel_q;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] safety_lvl,
  input logic       wr_en,
  input logic       wr_enable,
  input logic       wr_chg_en,
  input logic [2:0] wr_psel,
  input logic       kick,
  input logic       wdt_en,
  input logic       chg_en,
  input logic [2:0] psel,
  input logic       wdt_rst_req
);
  // length of the current unlock window, restarted by an unlocking write
  logic [2:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (wr_en && wr_chg_en && wr_enable)
      run_q <= 3'd1;
    else if (chg_en && run_q != 3'd7)
      run_q <= run_q + 3'd1;
    else if (!chg_en)
      run_q <= '0;
  end

  a_r3_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    chg_en |-> (run_q <= 3'd4));

  a_r4_fall_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_en) |-> ($past(chg_en) && $past(wr_en) && !$past(wr_enable)
                       && ($past(safety_lvl) != 2'b10)));

  a_r2_rise_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_en) |-> ($past(wr_en && wr_enable) || ($past(safety_lvl) == 2'b10)));

  a_r6_lock_holds_on: assert property (@(posedge clk) disable iff (!rst_n)
    (safety_lvl == 2'b10) |=> wdt_en);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> !wdt_rst_req);

  a_r8_kick_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !wdt_rst_req);

  a_r10_req_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> $past(wdt_en));

  a_r11_psel_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (psel == $past(wr_psel)));
endmodule

bind wdog_core wdog_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .safety_lvl  (safety_lvl),
  .wr_en       (wr_en),
  .wr_enable   (wr_enable),
  .wr_chg_en   (wr_chg_en),
  .wr_psel     (wr_psel),
  .kick        (kick),
  .wdt_en      (wdt_en),
  .chg_en      (chg_en),
  .psel        (psel),
  .wdt_rst_req (wdt_rst_req)
);

// File: tb/sim_wdog_core.sv
`timescale 1ns/1ps
module sim_wdog_core;
  localparam int DIV = 10;            // periods 16 .. 2048 cycles
  localparam int LIM0 = 1 << (14 - DIV);

  logic       clk, rst_n, en_default, wr_en, wr_enable, wr_chg_en, kick;
  logic [1:0] safety_lvl;
  logic [2:0] wr_psel;
  logic       wdt_en, chg_en, wdt_rst_req;
  logic [2:0] psel;

  int n_chk, n_bad;
  bit done;

  wdog_core #(.DIV_SHIFT(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .en_default(en_default), .safety_lvl(safety_lvl),
    .wr_en(wr_en), .wr_enable(wr_enable), .wr_chg_en(wr_chg_en), .wr_psel(wr_psel),
    .kick(kick), .wdt_en(wdt_en), .chg_en(chg_en), .psel(psel), .wdt_rst_req(wdt_rst_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(input logic en, input logic ce, input logic [2:0] s);
    wr_en = 1'b1; wr_enable = en; wr_chg_en = ce; wr_psel = s;
    @(negedge clk);
    wr_en = 1'b0; wr_enable = 1'b0; wr_chg_en = 1'b0;
  endtask

  task automatic kick_p();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  // returns falling edges until a request is seen, 0 if none within maxn
  task automatic wait_req(input int maxn, output int n);
    n = 0;
    for (int i = 1; i <= maxn; i++) begin
      @(negedge clk);
      if (wdt_rst_req) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic do_reset(input logic def);
    @(negedge clk);
    rst_n = 1'b0; en_default = def;
    tick(3);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    int n;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; en_default = 1'b0; safety_lvl = 2'b00;
    wr_en = 1'b0; wr_enable = 1'b0; wr_chg_en = 1'b0; wr_psel = 3'd0; kick = 1'b0;

    // R1 reset state, watchdog off
    do_reset(1'b0);
    chk("R1 en", int'(wdt_en), 0);
    chk("R1 chg", int'(chg_en), 0);
    chk("R1 psel", int'(psel), 0);
    chk("R1 req", int'(wdt_rst_req), 0);
    tick(4);
    // R10 disabled: no request
    wait_req(60, n);
    chk("R10 idle no req", n, 0);

    // R7 sweep every select code: first and second period, R2 / R11 readback
    for (int s = 0; s < 8; s++) begin
      int lim;
      lim = 1 << (14 + s - DIV);
      wr(1'b1, 1'b0, 3'(s));
      chk("R2 en after write", int'(wdt_en), 1);
      chk("R11 psel", int'(psel), s);
      wait_req(lim + 5, n);
      chk($sformatf("R7 first period sel %0d", s), n, lim);
      wait_req(lim + 5, n);
      chk($sformatf("R7 repeat period sel %0d", s), n, lim);
    end

    // R9 select change restarts, same select does not
    wr(1'b1, 1'b0, 3'd0);
    wait_req(LIM0 + 5, n);
    chk("R9 change restarts", n, LIM0);
    tick(4);
    wr(1'b1, 1'b0, 3'd0);
    wait_req(LIM0 + 5, n);
    chk("R9 same select keeps count", n, LIM0 - 5);

    // R8 kick restarts the count
    tick(9);
    kick_p();
    wait_req(LIM0 + 5, n);
    chk("R8 period after kick", n, LIM0);
    for (int k = 0; k < 5; k++) begin
      wait_req(LIM0 - 4, n);
      chk("R8 regular kicks suppress req", n, 0);
      kick_p();
    end
    wait_req(LIM0 + 5, n);
    chk("R8 req after last kick", n, LIM0);

    // R3 / R4 unlock window, clear at the last allowed edge
    wr(1'b1, 1'b1, 3'd0);
    for (int k = 0; k < 3; k++) begin
      chk("R3 chg open", int'(chg_en), 1);
      tick(1);
    end
    chk("R3 chg open last", int'(chg_en), 1);
    wr(1'b0, 1'b0, 3'd0);
    chk("R4 clear in window", int'(wdt_en), 0);
    chk("R3 chg closed", int'(chg_en), 0);
    wait_req(3 * LIM0, n);
    chk("R10 disabled after clear", n, 0);

    // R4 immediate clear
    wr(1'b1, 1'b0, 3'd0);
    wr(1'b1, 1'b1, 3'd0);
    wr(1'b0, 1'b0, 3'd0);
    chk("R4 clear next cycle", int'(wdt_en), 0);
    // R10 full first period on enable
    wr(1'b1, 1'b0, 3'd0);
    wait_req(LIM0 + 5, n);
    chk("R10 full period after enable", n, LIM0);

    // R5 clear after the window closed is ignored
    wr(1'b1, 1'b1, 3'd0);
    chk("R3 set while running keeps en", int'(wdt_en), 1);
    tick(4);
    chk("R3 chg expired", int'(chg_en), 0);
    wr(1'b0, 1'b0, 3'd0);
    chk("R5 late clear ignored", int'(wdt_en), 1);
    // R5 first write without run bit: nothing unlocks
    wr(1'b0, 1'b1, 3'd0);
    chk("R3 unlock needs run bit", int'(chg_en), 0);
    chk("R5 clear without unlock ignored a", int'(wdt_en), 1);
    wr(1'b0, 1'b0, 3'd0);
    chk("R5 clear without unlock ignored b", int'(wdt_en), 1);

    // R6 safety lock
    safety_lvl = 2'b10;
    wr(1'b1, 1'b1, 3'd0);
    wr(1'b0, 1'b0, 3'd0);
    chk("R6 locked cannot clear", int'(wdt_en), 1);
    safety_lvl = 2'b00;
    tick(1);
    wr(1'b1, 1'b1, 3'd0);
    wr(1'b0, 1'b0, 3'd0);
    chk("R6 unlocked level clears", int'(wdt_en), 0);
    safety_lvl = 2'b10;
    tick(1);
    chk("R6 lock forces on", int'(wdt_en), 1);
    safety_lvl = 2'b01;
    tick(1);
    wr(1'b1, 1'b1, 3'd0);
    wr(1'b0, 1'b0, 3'd0);
    chk("R6 level 1 not locked", int'(wdt_en), 0);
    safety_lvl = 2'b00;

    // R1 reset with watchdog defaulting on
    do_reset(1'b1);
    chk("R1 en default on", int'(wdt_en), 1);
    chk("R1 chg after reset", int'(chg_en), 0);
    chk("R1 psel after reset", int'(psel), 0);
    wait_req(LIM0 + 10, n);
    chk("R1 first req after reset", n, LIM0 + 2);

    summary();
    $finish;
  end
endmodule